// File: doc/BRIEF.md
# Transmitter Delay Compensation for a Flexible-Data-Rate CAN Controller

In the fast data phase of a CAN frame, the loop delay through the transceiver can be longer than one bit time. The node then cannot check its own transmitted bits at the normal sample point. This block places a secondary sample point for that check. The point is a number of controller clock cycles after the start of each transmitted bit.

The delay value comes from one of two sources. In automatic mode the block measures it, by counting cycles from a dominant transmit edge until the dominant level reaches the receive pin. In manual mode it takes the delay from configuration. A signed offset is then added to the delay. The offset may be zero or negative, so the sample point can sit at or before the loop delay. The result is clamped into the range of the delay field.

Every transmitted bit is queued with its start time. When a bit's secondary sample point arrives, the receive pin is compared with the queued bit, and a mismatch produces a one-cycle bit-error pulse. Bit timing segments, frame sequencing and the transceiver itself belong to other blocks.

Top module: `txdelay_comp`

## Requirements
- R1: The 2-bit mode field selects the behaviour. Value 00 turns compensation off. Value 01 is manual and uses the configured delay. Values 10 and 11 are both automatic and use the measured delay.
- R2: An automatic measurement starts on a start strobe. The strobe is given in the cycle where the transmit level first becomes dominant (0). The measured delay is the number of cycles from that cycle to the first cycle in which the receive pin is dominant, and is 0 if the receive pin is dominant in the strobe cycle itself.
- R3: If the receive pin is still recessive 63 cycles after the strobe, the measured delay saturates at 63 and the timeout flag is set. The timeout flag clears at the next accepted start strobe.
- R4: The sample position is the delay plus the offset, in clock cycles. The offset is read as a 7-bit two's complement value (-64..+63), and zero and negative offsets are accepted.
- R5: If the delay plus offset is negative while compensation is on, the sample position is 0 and a warning flag is set. The warning flag stays set until reset.
- R6: If the delay plus offset exceeds 63, the sample position is 63.
- R7: Each bit start strobe queues the transmit level of that cycle. The receive pin is sampled in the cycle that lies sample-position cycles after the bit start cycle. The bit-error output is high for exactly one cycle, two cycles after that sample cycle, if and only if the sampled receive level differs from the queued bit.
- R8: With the mode at 00, no bits are queued and the bit-error output stays low whatever the receive pin does.
- R9: Mode, offset and manual delay are taken only on a start strobe that arrives while no measurement is running. Changes at other times, and a strobe during a measurement, have no effect on the sample position.
- R10: The measured delay is presented on a status output and keeps its value until the next automatic measurement completes. A manual or off load leaves it unchanged.
- R11: The queue holds up to the queue depth (16 by default) bits in flight. An accepted start strobe discards all queued bits, so none of them produces a bit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txBit | input | 1 | Transmit level driven to the transceiver (0 = dominant) |
| bitStart | input | 1 | High in the first cycle of each transmitted bit |
| rxPin | input | 1 | Receive pin level (0 = dominant) |
| measStart | input | 1 | Start strobe: loads configuration and, in automatic mode, starts a measurement |
| cfgMode | input | 2 | Compensation mode (00 off, 01 manual, 1x automatic) |
| cfgOffset | input | OFS_W (7) | Signed offset added to the delay |
| cfgDelay | input | DLY_W (6) | Manual delay value |
| bitErr | output | 1 | One-cycle pulse on a secondary-sample mismatch |
| sspPos | output | DLY_W (6) | Effective secondary sample position |
| delayMeas | output | DLY_W (6) | Last measured loop delay |
| measTimeout | output | 1 | Last measurement saw no dominant receive level |
| cfgWarn | output | 1 | Sticky flag: delay plus offset fell below zero |

## Verification
The assertions rely on three conditions on the inputs. An automatic start strobe comes exactly at a recessive-to-dominant transmit edge. No more than the queue depth of bits are awaiting their sample at once. Bit starts never fall inside a running measurement. The stimulus meets all three. Every automatic strobe follows a recessive cycle. The bit periods are at least four cycles and the largest sample position used with traffic is 40. Bit traffic begins only after each measurement window has been drained with the bus recessive. The receive pin is a delayed copy of the transmit level, and single flipped cycles are placed either exactly on or away from the expected sample cycles.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_MANUAL   = 2'b01,
    MODE_AUTO     = 2'b10,
    MODE_AUTO_ALT = 2'b11
  } tdcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic captureDelay;
    logic timeoutHit;
  } tdcStrobe_t;
endpackage

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             measStart,
  input  logic             autoReq,
  input  logic             txBit,
  input  logic             rxPin,
  output tdcStrobe_t       strb,
  output logic [DLY_W-1:0] measCount
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  typedef enum logic {ST_IDLE, ST_MEAS} ctrlState_e;

  ctrlState_e       state, stateNext;
  logic [DLY_W-1:0] cnt, cntNext;
  logic             txPrev;

  always_comb begin
    strb      = '0;
    stateNext = state;
    cntNext   = cnt;
    measCount = cnt;
    case (state)
      ST_IDLE: begin
        if (measStart) begin
          strb.loadCfg = 1'b1;
          if (autoReq) begin
            if (!rxPin) begin
              strb.captureDelay = 1'b1;
              measCount         = '0;
            end else begin
              stateNext = ST_MEAS;
              cntNext   = DLY_W'(1);
            end
          end
        end
      end
      ST_MEAS: begin
        if (!rxPin) begin
          strb.captureDelay = 1'b1;
          stateNext         = ST_IDLE;
        end else if (cnt == CNT_MAX) begin
          strb.captureDelay = 1'b1;
          strb.timeoutHit   = 1'b1;
          stateNext         = ST_IDLE;
        end else begin
          cntNext = cnt + DLY_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      txPrev <= 1'b1;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      txPrev <= txBit;
    end
  end

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (measStart && autoReq && state == ST_IDLE) |-> (!txBit && txPrev)) // R2
    else $error("automatic start strobe without a dominant transmit edge");

  AST_MEAS_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MEAS && cnt == CNT_MAX) |=> (state == ST_IDLE)) // R3
    else $error("measurement ran past its limit");
endmodule

// File: rtl/tdc_dpath.sv
module tdc_dpath
  import tdc_pkg::*;
#(
  parameter int DLY_W   = 6,
  parameter int OFS_W   = 7,
  parameter int Q_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tdcStrobe_t       strb,
  input  logic [DLY_W-1:0] measCount,
  input  logic [1:0]       cfgMode,
  input  logic [OFS_W-1:0] cfgOffset,
  input  logic [DLY_W-1:0] cfgDelay,
  input  logic             bitStart,
  input  logic             txBit,
  input  logic             rxPin,
  output logic             bitErr,
  output logic [DLY_W-1:0] sspPos,
  output logic [DLY_W-1:0] delayMeas,
  output logic             measTimeout,
  output logic             cfgWarn
);
  localparam int STAMP_W = DLY_W + 1;
  localparam int EXT_W   = (OFS_W > DLY_W + 1) ? OFS_W : DLY_W + 1;
  localparam int SUM_W   = EXT_W + 1;
  localparam int PTR_W   = $clog2(Q_DEPTH);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;
  localparam logic signed [SUM_W-1:0] SUM_MAX = $signed({{(SUM_W-DLY_W){1'b0}}, DLY_MAX});

  tdcMode_e         modeR;
  logic [OFS_W-1:0] ofsR;
  logic [DLY_W-1:0] manDlyR;
  logic [DLY_W-1:0] dlySrc;
  logic signed [SUM_W-1:0] sum;
  logic             enabled;

  // configuration, taken only on an accepted strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR   <= MODE_OFF;
      ofsR    <= '0;
      manDlyR <= '0;
    end else if (strb.loadCfg) begin
      modeR   <= tdcMode_e'(cfgMode);
      ofsR    <= cfgOffset;
      manDlyR <= cfgDelay;
    end
  end

  assign enabled = (modeR != MODE_OFF);
  assign dlySrc  = (modeR == MODE_MANUAL) ? manDlyR : delayMeas;
  assign sum     = $signed({{(SUM_W-DLY_W){1'b0}}, dlySrc})
                 + $signed({{(SUM_W-OFS_W){ofsR[OFS_W-1]}}, ofsR});

  always_comb begin
    if (sum[SUM_W-1])      sspPos = '0;
    else if (sum > SUM_MAX) sspPos = DLY_MAX;
    else                    sspPos = sum[DLY_W-1:0];
  end

  // measurement result and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayMeas   <= '0;
      measTimeout <= 1'b0;
      cfgWarn     <= 1'b0;
    end else begin
      if (strb.captureDelay) delayMeas <= measCount;
      if (strb.loadCfg)         measTimeout <= 1'b0;
      else if (strb.timeoutHit) measTimeout <= 1'b1;
      if (enabled && sum[SUM_W-1]) cfgWarn <= 1'b1;
    end
  end

  // queue of transmitted bits with their start stamps
  logic                qBit   [Q_DEPTH];
  logic [STAMP_W-1:0]  qStamp [Q_DEPTH];
  logic [PTR_W:0]      wrPtr, rdPtr;
  logic [STAMP_W-1:0]  timeNow, age, due;
  logic                rxDly, push, pop, qEmpty, qFull;
  logic [PTR_W-1:0]    rdIdx, wrIdx;

  assign rdIdx  = rdPtr[PTR_W-1:0];
  assign wrIdx  = wrPtr[PTR_W-1:0];
  assign qEmpty = (wrPtr == rdPtr);
  assign qFull  = (wrPtr[PTR_W] != rdPtr[PTR_W]) && (wrIdx == rdIdx);
  assign push   = bitStart && enabled && !strb.loadCfg;
  assign age    = timeNow - qStamp[rdIdx];
  assign due    = {1'b0, sspPos} + STAMP_W'(1);
  assign pop    = !qEmpty && (age == due);

  always_ff @(posedge clk) begin
    if (push) begin
      qBit[wrIdx]   <= txBit;
      qStamp[wrIdx] <= timeNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      timeNow <= '0;
      rxDly   <= 1'b1;
      bitErr  <= 1'b0;
    end else begin
      timeNow <= timeNow + STAMP_W'(1);
      rxDly   <= rxPin;
      bitErr  <= pop && (rxDly != qBit[rdIdx]);
      if (strb.loadCfg) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (push) wrPtr <= wrPtr + (PTR_W+1)'(1);
        if (pop)  rdPtr <= rdPtr + (PTR_W+1)'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !qFull) // R11
    else $error("bit queue overflow");

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> ($stable(modeR) && $stable(ofsR) && $stable(manDlyR))) // R9
    else $error("configuration changed without a load");

  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureDelay |=> $stable(delayMeas)) // R10
    else $error("measured delay changed without a capture");

  AST_TIMEOUT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measTimeout) |-> (delayMeas == DLY_MAX)) // R3
    else $error("timeout without saturated delay");

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (modeR == MODE_OFF && $past(modeR) == MODE_OFF) |-> !bitErr) // R8
    else $error("bit error while compensation is off");

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWarn) |-> cfgWarn) // R5
    else $error("warning flag cleared");
endmodule

// File: rtl/txdelay_comp.sv
module txdelay_comp
  import tdc_pkg::*;
#(
  parameter int DLY_W   = 6,
  parameter int OFS_W   = 7,
  parameter int Q_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txBit,
  input  logic             bitStart,
  input  logic             rxPin,
  input  logic             measStart,
  input  logic [1:0]       cfgMode,
  input  logic [OFS_W-1:0] cfgOffset,
  input  logic [DLY_W-1:0] cfgDelay,
  output logic             bitErr,
  output logic [DLY_W-1:0] sspPos,
  output logic [DLY_W-1:0] delayMeas,
  output logic             measTimeout,
  output logic             cfgWarn
);
  tdcStrobe_t       strb;
  logic [DLY_W-1:0] measCount;

  tdc_ctrl #(.DLY_W(DLY_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .measStart (measStart),
    .autoReq   (cfgMode[1]),
    .txBit     (txBit),
    .rxPin     (rxPin),
    .strb      (strb),
    .measCount (measCount)
  );

  tdc_dpath #(.DLY_W(DLY_W), .OFS_W(OFS_W), .Q_DEPTH(Q_DEPTH)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .measCount   (measCount),
    .cfgMode     (cfgMode),
    .cfgOffset   (cfgOffset),
    .cfgDelay    (cfgDelay),
    .bitStart    (bitStart),
    .txBit       (txBit),
    .rxPin       (rxPin),
    .bitErr      (bitErr),
    .sspPos      (sspPos),
    .delayMeas   (delayMeas),
    .measTimeout (measTimeout),
    .cfgWarn     (cfgWarn)
  );
endmodule

// File: tb/test_txdelay_comp.sv
`timescale 1ns/1ps
module test_txdelay_comp;
  logic       clk = 1'b0;
  logic       rstN;
  logic       txBit, bitStart, rxPin, measStart;
  logic [1:0] cfgMode;
  logic [6:0] cfgOffset;
  logic [5:0] cfgDelay;
  logic       bitErr, measTimeout, cfgWarn;
  logic [5:0] sspPos, delayMeas;

  always #4 clk = ~clk;

  txdelay_comp i_txdelay_comp (
    .clk(clk), .rstN(rstN), .txBit(txBit), .bitStart(bitStart), .rxPin(rxPin),
    .measStart(measStart), .cfgMode(cfgMode), .cfgOffset(cfgOffset), .cfgDelay(cfgDelay),
    .bitErr(bitErr), .sspPos(sspPos), .delayMeas(delayMeas),
    .measTimeout(measTimeout), .cfgWarn(cfgWarn)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int loopDly = 5;
  int errCnt = 0;
  bit txRing [256];
  bit rxRing [256];
  bit flipSet [int];

  // behavioural reference state
  int mMode = 0, mOfs = 0, mMan = 0, mMeas = 0, mStart = 0;
  bit mTo = 0, mWarn = 0, measuring = 0, eErr = 0;
  int qDue [$];
  bit qBit [$];

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int rawSum();
    return ((mMode == 1) ? mMan : mMeas) + mOfs;
  endfunction

  function automatic int expSsp();
    int s = rawSum();
    if (s < 0) return 0;
    if (s > 63) return 63;
    return s;
  endfunction

  task automatic modelEdge(input bit bs, input bit tx, input bit ms, input bit rx);
    int  s     = expSsp();
    bit  en    = (mMode != 0);
    bit  loaded = 0;
    eErr = 0;
    if (qDue.size() > 0 && qDue[0] == cyc - 1) begin
      eErr = (rxRing[(cyc-1) & 255] != qBit[0]);
      void'(qDue.pop_front());
      void'(qBit.pop_front());
    end
    if (en && rawSum() < 0) mWarn = 1;
    if (measuring) begin
      if (!rx) begin
        mMeas = cyc - mStart; measuring = 0;
      end else if (cyc - mStart == 63) begin
        mMeas = 63; mTo = 1; measuring = 0;
      end
    end else if (ms) begin
      loaded = 1;
      mMode = int'(cfgMode);
      mOfs  = int'($signed(cfgOffset));
      mMan  = int'(cfgDelay);
      mTo   = 0;
      qDue.delete();
      qBit.delete();
      if (cfgMode[1]) begin
        if (!rx) mMeas = 0;
        else begin measuring = 1; mStart = cyc; end
      end
    end
    if (bs && en && !loaded) begin
      qDue.push_back(cyc + s);
      qBit.push_back(tx);
    end
  endtask

  task automatic tick(input bit bs, input bit tx, input bit ms);
    bit rxv;
    bitStart  = bs;
    txBit     = tx;
    measStart = ms;
    txRing[cyc & 255] = tx;
    rxv = (loopDly == 0) ? tx : txRing[(cyc - loopDly) & 255];
    if (flipSet.exists(cyc)) rxv = !rxv;
    rxPin = rxv;
    rxRing[cyc & 255] = rxv;
    @(posedge clk);
    #1;
    modelEdge(bs, tx, ms, rxv);
    if (bitErr) errCnt++;
    cmp("R7 bitErr", int'(bitErr), int'(eErr));
    cmp("R4 sspPos", int'(sspPos), expSsp());
    cmp("R2 delayMeas", int'(delayMeas), mMeas);
    cmp("R3 measTimeout", int'(measTimeout), int'(mTo));
    cmp("R5 cfgWarn", int'(cfgWarn), int'(mWarn));
    cyc++;
  endtask

  task automatic measure(input logic [1:0] mode, input int ofs, input int dly);
    cfgMode = mode; cfgOffset = 7'(ofs); cfgDelay = 6'(dly);
    tick(0, 1, 0);
    tick(0, 0, 1);
    repeat (70) tick(0, 0, 0);
    repeat (loopDly + 4) tick(0, 1, 0);
  endtask

  function automatic bit pat(input int b, input bit allDom);
    if (allDom) return 1'b0;
    return (((b * 5 + 1) % 3) == 0);
  endfunction

  task automatic sendBits(input int n, input int per, input bit allDom, input int drain);
    for (int b = 0; b < n; b++)
      for (int c = 0; c < per; c++)
        tick(c == 0, pat(b, allDom), 0);
    repeat (drain) tick(0, 1, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog covering R1 to R11 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int s0, e0;
    for (int i = 0; i < 256; i++) begin txRing[i] = 1; rxRing[i] = 1; end
    rstN = 0; txBit = 1; bitStart = 0; rxPin = 1; measStart = 0;
    cfgMode = 2'b00; cfgOffset = '0; cfgDelay = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // reset state, mode off (R1)
    cmp("R1 reset bitErr", int'(bitErr), 0);
    cmp("R1 reset sspPos", int'(sspPos), 0);
    cmp("R10 reset delayMeas", int'(delayMeas), 0);
    cmp("R5 reset cfgWarn", int'(cfgWarn), 0);
    repeat (5) tick(0, 1, 0);

    // S1: automatic, loop 5, offset +3
    loopDly = 5;
    measure(2'b10, 3, 0);
    cmp("R2 measured loop", int'(delayMeas), 5);
    cmp("R4 positive offset", int'(sspPos), 8);
    s0 = cyc; e0 = errCnt;
    flipSet[s0 + 30 + 8] = 1;
    flipSet[s0 + 70 + 8] = 1;
    flipSet[s0 + 50 + 2] = 1;   // off the sample point: no effect
    sendBits(12, 10, 0, 70);
    cmp("R7 error pulses", errCnt - e0, 2);

    // S2: negative offset samples before the loop delay
    measure(2'b10, -2, 0);
    cmp("R4 negative offset", int'(sspPos), 3);
    s0 = cyc; e0 = errCnt;
    flipSet[s0 + 20 + 3] = 1;
    sendBits(8, 10, 1, 70);   // first bit sees the idle level
    cmp("R7 early sample pulses", errCnt - e0, 2);
    cmp("R5 no warning yet", int'(cfgWarn), 0);

    // S3: negative sum clamps to zero and warns
    measure(2'b10, -10, 0);
    cmp("R5 clamp to zero", int'(sspPos), 0);
    cmp("R5 warning set", int'(cfgWarn), 1);
    measure(2'b10, 0, 0);
    cmp("R5 warning sticky", int'(cfgWarn), 1);
    cmp("R4 zero offset", int'(sspPos), 5);

    // S4: manual delay and upper saturation
    measure(2'b01, 20, 60);
    cmp("R6 manual saturates", int'(sspPos), 63);
    cmp("R1 manual keeps status", int'(delayMeas), 5);
    cmp("R10 status held", int'(delayMeas), 5);
    measure(2'b10, 63, 0);
    cmp("R6 automatic saturates", int'(sspPos), 63);

    // S5: timeout, and a strobe during measurement is ignored
    repeat (120) tick(0, 1, 0);
    loopDly = 100;
    cfgMode = 2'b10; cfgOffset = 7'd0;
    tick(0, 1, 0);
    tick(0, 0, 1);
    repeat (10) tick(0, 0, 0);
    cfgMode = 2'b00; cfgOffset = 7'h7F;
    tick(0, 0, 1);
    repeat (60) tick(0, 0, 0);
    cmp("R3 saturated delay", int'(delayMeas), 63);
    cmp("R3 timeout flag", int'(measTimeout), 1);
    cmp("R9 strobe while measuring", int'(sspPos), 63);
    repeat (110) tick(0, 1, 0);
    loopDly = 5;
    measure(2'b10, 0, 0);
    cmp("R3 timeout cleared", int'(measTimeout), 0);
    cmp("R2 remeasured", int'(delayMeas), 5);
    cfgOffset = 7'd20; cfgMode = 2'b01;
    repeat (5) tick(0, 1, 0);
    cmp("R9 change without strobe", int'(sspPos), 5);

    // S6: off mode never flags
    measure(2'b00, 0, 0);
    s0 = cyc; e0 = errCnt;
    for (int k = 0; k < 8; k++) flipSet[s0 + k * 10 + 5] = 1;
    sendBits(8, 10, 0, 70);
    cmp("R8 off mode quiet", errCnt - e0, 0);
    cmp("R8 off mode timeout untouched", int'(measTimeout), 0);

    // S7: alternate automatic code, deep queue, then flush
    repeat (50) tick(0, 1, 0);
    loopDly = 40;
    measure(2'b11, 0, 0);
    cmp("R1 alternate automatic code", int'(delayMeas), 40);
    cmp("R11 deep sample position", int'(sspPos), 40);
    s0 = cyc; e0 = errCnt;
    flipSet[s0 + 8 + 40] = 1;
    flipSet[s0 + 36 + 40] = 1;
    sendBits(14, 4, 0, 70);
    cmp("R11 many bits in flight", errCnt - e0, 2);
    s0 = cyc; e0 = errCnt;
    flipSet[s0 + 4 + 40] = 1;
    flipSet[s0 + 12 + 40] = 1;
    sendBits(6, 4, 0, 0);
    measure(2'b01, 0, 40);
    repeat (20) tick(0, 1, 0);
    cmp("R11 flushed on load", errCnt - e0, 0);
    cmp("R1 manual position", int'(sspPos), 40);

    summary();
    $finish;
  end
endmodule